// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block collects 16-bit command words from a three-wire serial port made of an active-low select, a serial clock and a data line. Bits arrive most significant first and are taken on falling serial clock edges while select is low. When select returns high, the block checks the frame. A frame that carried at least 16 bits delivers its last 16 bits to the system clock domain as one word with a single-cycle valid strobe. A frame with fewer bits is thrown away and reported with a single-cycle discard strobe. The top four bits of the word are the command code and the low twelve are the data. Decoding them is left to downstream logic.

A serial output repeats the input stream 16 falling edges later, so several receivers can sit in a chain on one select line. An asynchronous clear input wipes the shift register and the serial output, and it condemns any frame in progress. The word and its strobe cross into the system clock through a synchronized toggle. The frame-length counter saturates, so a frame of any length is judged correctly.

Top module: `serial_cmd_rx`

## Requirements
- R1: The first bit shifted in a frame lands in word_o[15] and the last in word_o[0]. word_o[15:12] carries the command code and word_o[11:0] the data.
- R2: sdi_i is sampled only on falling edges of sclk_i while cs_ni is low. Serial clock edges while cs_ni is high shift nothing.
- R3: A frame of exactly 16 bits produces one word_valid_o pulse carrying the word, within 4 clk_i cycles after cs_ni rises.
- R4: A frame of fewer than 16 bits, including zero, produces one drop_o pulse and no word_valid_o pulse, and word_o keeps its previous value.
- R5: A frame longer than 16 bits is accepted and delivers its last 16 bits. Acceptance holds for any length, including lengths past the counter width, such as 40 bits.
- R6: sdo_o is updated on falling sclk_i edges and equals the sdi_i bit taken 16 shifting edges earlier.
- R7: clr_ni low clears the shift register and drives sdo_o low. The frame in progress is discarded even if 16 or more bits follow within it, and the next frame is received normally.
- R8: After rst_ni, word_o is 0, word_valid_o and drop_o are low, sdo_o is low and the shift register holds zeros.
- R9: word_valid_o and drop_o are single-cycle pulses, never high together, and word_o changes only in a cycle where word_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_ni | input | 1 | Active-low asynchronous clear of the serial side |
| cs_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, data taken on falling edge |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdo_o | output | 1 | Serial data out, input delayed by 16 edges |
| word_o | output | 16 | Last accepted word |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| drop_o | output | 1 | One-cycle strobe for a discarded frame |

## Verification
The bench targets frame lengths on both sides of 16. It uses 15, 16 and 17 bits, zero-bit and one-bit frames, and a 40-bit frame. A design that wraps its bit counter would reject the 40-bit frame, and one that uses a greater-than test would drop exact 16-bit words. Serial clock edges sent while select is high expose a shifter that ignores select, because the stale word then comes out of sdo_o corrupted. A clear pulse inside a frame, followed by more than 16 bits, catches a design that restarts counting after the clear instead of discarding the frame.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/srx_shift.sv
`timescale 1ns/1ps
module srx_shift #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              sclk_i,
  input  logic              arst_ni,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic              start_tgl_i,
  output logic [WORD_W-1:0] shreg_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              seen_o,
  output logic              sdo_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  always_ff @(negedge sclk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      shreg_o <= '0;
      cnt_o   <= '0;
      seen_o  <= 1'b0;
      sdo_o   <= 1'b0;
    end else if (!cs_ni) begin
      shreg_o <= {shreg_o[WORD_W-2:0], sdi_i};
      sdo_o   <= shreg_o[WORD_W-1];
      if (seen_o != start_tgl_i) begin
        // first edge of a new frame
        seen_o <= start_tgl_i;
        cnt_o  <= CNT_W'(1);
      end else if (cnt_o != CNT_MAX) begin
        cnt_o <= cnt_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/srx_frame.sv
`timescale 1ns/1ps
module srx_frame #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              cs_ni,
  input  logic              rst_ni,
  input  logic              arst_ni,
  input  logic [WORD_W-1:0] shreg_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              seen_i,
  output logic              start_tgl_o,
  output logic [WORD_W-1:0] hold_o,
  output logic              acc_tgl_o,
  output logic              drp_tgl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic abort_q;
  logic full;

  // frame start marker; clear poisons the frame until the next select fall
  always_ff @(negedge cs_ni or negedge arst_ni) begin
    if (!arst_ni) begin
      start_tgl_o <= 1'b0;
      abort_q     <= 1'b1;
    end else begin
      start_tgl_o <= ~start_tgl_o;
      abort_q     <= 1'b0;
    end
  end

  assign full = (cnt_i == CNT_MAX) && (seen_i == start_tgl_o) && !abort_q;

  always_ff @(posedge cs_ni or negedge arst_ni) begin
    if (!arst_ni)  hold_o <= '0;
    else if (full) hold_o <= shreg_i;
  end

  // toggles survive clear so the system side sees no false event
  always_ff @(posedge cs_ni or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_tgl_o <= 1'b0;
      drp_tgl_o <= 1'b0;
    end else if (full) begin
      acc_tgl_o <= ~acc_tgl_o;
    end else begin
      drp_tgl_o <= ~drp_tgl_o;
    end
  end
endmodule

// File: rtl/srx_pulse_sync.sv
`timescale 1ns/1ps
module srx_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = q[STAGES] ^ q[STAGES-1];
endmodule

// File: rtl/serial_cmd_rx.sv
`timescale 1ns/1ps
module serial_cmd_rx
  import srx_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  localparam int unsigned CNT_W      = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              drop_o
);
  logic              arst_n;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              seen, start_tgl;
  logic [WORD_W-1:0] hold;
  logic [1:0]        tgl, pulse;

  assign arst_n = rst_ni & clr_ni;

  srx_shift #(.WORD_W(WORD_W)) u_shift (
    .sclk_i(sclk_i), .arst_ni(arst_n), .cs_ni(cs_ni), .sdi_i(sdi_i),
    .start_tgl_i(start_tgl), .shreg_o(shreg), .cnt_o(cnt), .seen_o(seen),
    .sdo_o(sdo_o)
  );

  srx_frame #(.WORD_W(WORD_W)) u_frame (
    .cs_ni(cs_ni), .rst_ni(rst_ni), .arst_ni(arst_n), .shreg_i(shreg),
    .cnt_i(cnt), .seen_i(seen), .start_tgl_o(start_tgl), .hold_o(hold),
    .acc_tgl_o(tgl[0]), .drp_tgl_o(tgl[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_sync
    srx_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .tgl_i(tgl[g]), .pulse_o(pulse[g])
    );
  end

  // hold is stable for SYNC_STAGES cycles before the pulse arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
      drop_o       <= 1'b0;
    end else begin
      word_valid_o <= pulse[0];
      drop_o       <= pulse[1];
      if (pulse[0]) word_o <= hold;
    end
  end
endmodule

// File: rtl/srx_chk.sv
`timescale 1ns/1ps
module srx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_ni,
  input logic              cs_ni,
  input logic              sclk_i,
  input logic              sdo_o,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              drop_o
);
  // R9
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_o && drop_o));

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  // R4
  drop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> !drop_o);

  // R9
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> word_valid_o);

  // R8
  reset_out_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (word_o == '0 && !word_valid_o && !drop_o && !sdo_o));

  // R7
  clr_sdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && $past(!clr_ni)) |-> !sdo_o);

  // R2
  idle_shift_chk: assert property (@(negedge sclk_i) disable iff (!rst_ni || !clr_ni)
    cs_ni |=> $stable(sdo_o));
endmodule

bind serial_cmd_rx srx_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_serial_cmd_rx.sv
`timescale 1ns/1ps
module sim_serial_cmd_rx;
  typedef struct packed {
    logic [7:0]  nb;
    logic [47:0] d;
    logic        acc;
    logic [15:0] w;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd16, 48'h0000_0000_A5C3, 1'b1, 16'hA5C3},  // R1 R3
    '{8'd15, 48'h0000_0000_1234, 1'b0, 16'h0000},  // R4
    '{8'd0,  48'h0,              1'b0, 16'h0000},  // R4 empty frame
    '{8'd32, 48'h0000_DEAD_BEEF, 1'b1, 16'hBEEF},  // R5
    '{8'd17, 48'h0000_0001_8001, 1'b1, 16'h8001},  // R5
    '{8'd40, 48'h0012_3456_7890, 1'b1, 16'h7890},  // R5 saturation
    '{8'd16, 48'h0,              1'b1, 16'h0000},  // R3
    '{8'd16, 48'h0000_0000_FFFF, 1'b1, 16'hFFFF},  // R3
    '{8'd1,  48'h1,              1'b0, 16'h0000}   // R4
  };

  logic clk = 0, rst_n = 0, clr_n = 1, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, valid, drop;
  logic [15:0] word;
  int n_tests = 0, n_fail = 0;
  int vcnt = 0, dcnt = 0;
  logic [15:0] last_word = '0;
  logic sdo_cap [64];
  int bidx = 0;

  always #2 clk = ~clk;

  serial_cmd_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sdi_i(sdi), .sdo_o(sdo), .word_o(word), .word_valid_o(valid), .drop_o(drop)
  );

  always @(negedge clk) if (rst_n) begin
    if (valid) begin vcnt++; last_word = word; end
    if (drop) dcnt++;
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    bidx = 0; #10 cs_n = 0; #10;
  endtask

  task automatic shift_bits(input int n, input logic [47:0] d);
    for (int i = 0; i < n; i++) begin
      sdi = d[n-1-i];
      #10 sclk = 1;
      #10 sclk = 0;
      #2 sdo_cap[bidx] = sdo;
      bidx++;
      #3;
    end
  endtask

  task automatic cs_high();
    #10 cs_n = 1; #60;
  endtask

  task automatic send(input int n, input logic [47:0] d);
    cs_low(); shift_bits(n, d); cs_high();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v0, d0, mis;
    #21 rst_n = 1;
    #20;
    // R8 reset state
    check(word == 16'h0 && !valid && !drop, "R8 outputs", {47'h0, word, valid}, 0);
    check(sdo == 1'b0, "R8 sdo", sdo, 0);

    // R6 delay, and R8 cleared shift register seen on first 16 outputs
    send(32, 48'h6B1D_93E4);
    mis = 0;
    for (int i = 0; i < 16; i++) if (sdo_cap[i] !== 1'b0) mis++;
    check(mis == 0, "R8 cleared shreg", mis, 0);
    mis = 0;
    for (int i = 16; i < 32; i++) if (sdo_cap[i] !== 1'(32'h6B1D_93E4 >> (31 - (i - 16)))) mis++;
    check(mis == 0, "R6 sdo delay", mis, 0);
    check(last_word == 16'h93E4, "R5 long frame", last_word, 16'h93E4);

    // R2 clock edges while deselected shift nothing
    sdi = 1;
    for (int i = 0; i < 5; i++) begin #10 sclk = 1; #10 sclk = 0; end
    v0 = vcnt;
    send(16, 48'h0F0F);
    mis = 0;
    for (int i = 0; i < 16; i++) if (sdo_cap[i] !== 1'(16'h93E4 >> (15 - i))) mis++;
    check(mis == 0, "R2 idle edges", mis, 0);
    check(vcnt == v0 + 1 && last_word == 16'h0F0F, "R3 word after idle", last_word, 16'h0F0F);

    // R7 clear inside a frame
    v0 = vcnt; d0 = dcnt;
    cs_low();
    shift_bits(8, 48'hFF);
    #5 clr_n = 0; #20 clr_n = 1; #5;
    check(sdo == 1'b0, "R7 sdo cleared", sdo, 0);
    shift_bits(20, 48'hABCDE);
    cs_high();
    check(vcnt == v0 && dcnt == d0 + 1, "R7 frame discarded", vcnt - v0, 0);
    check(word == 16'h0F0F, "R7 word kept", word, 16'h0F0F);
    send(16, 48'h5A5A);
    check(vcnt == v0 + 1 && last_word == 16'h5A5A, "R7 next frame", last_word, 16'h5A5A);

    // R3 latency: strobe within 4 clk cycles after select rises
    cs_low(); shift_bits(16, 48'hC35A);
    v0 = vcnt;
    #10 cs_n = 1;
    #16;
    check(vcnt == v0 + 1, "R3 latency", vcnt - v0, 1);
    #60;

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [15:0] exp_w;
      v0 = vcnt; d0 = dcnt;
      exp_w = VECS[k].acc ? VECS[k].w : word;
      send(int'(VECS[k].nb), VECS[k].d);
      if (VECS[k].acc)
        check(vcnt == v0 + 1 && dcnt == d0, "R3/R5 accept", vcnt - v0, 1);
      else
        check(vcnt == v0 && dcnt == d0 + 1, "R4 reject", dcnt - d0, 1);
      check(word == exp_w, "R1 word value", word, exp_w);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule